// File: doc/BRIEF.md
# Serial configuration image loader

This block is the master side of a one-bit serial configuration link to a programmable target device. On a start pulse it pulses the target's program-reset line low for a fixed number of cycles and releases it. It then waits, with a timeout, for the target to raise its init line. After that it takes image bytes from a valid/ready byte stream and shifts each one out most-significant bit first. Every bit gets its own full low-then-high cycle of the configuration clock.

Before each new byte the block looks at the target's done line. If done is already high, streaming stops early and the run counts as complete. If init falls while bytes are loading, the run aborts at once with a fault code. Once the byte marked last has been sent, the block keeps clocking out filler bytes of all ones until done rises or a cycle budget runs out. The target has no flow-control pin, so bits leave at a fixed rate set by a divider parameter.

At the end the block drops busy and holds either a success flag or an error code until the next start. An abort input returns it to idle from any state. In idle the program-reset line and the configuration clock both rest high.

Top module: `cfg_serial_loader`

## Requirements
- R1: After start, the program-reset output is low for exactly PROG_LOW_CYC clock cycles and then high, and the configuration clock has no falling edge before the init input has gone high.
- R2: If init has not gone high within INIT_TIMEOUT cycles after program-reset is released, the block ends with error code 1 (init timeout), no byte is accepted and no bit is clocked.
- R3: Each byte is sent bit 7 first down to bit 0. Each bit value is presented as the configuration clock falls. The clock stays low for HALF_DIV cycles and then high for HALF_DIV cycles, and data is stable while the clock is high.
- R4: The stream ready output is high only in the loading phase while the shifter is idle, the last byte has not been taken, init is high and done is low. A byte is transferred when valid and ready are both high on a clock edge.
- R5: If done is high at a byte boundary during loading, streaming stops and the run ends with success. No further image byte is accepted and no filler byte is sent.
- R6: If init is low at any cycle of the loading phase, the shifter stops at once and the run ends with error code 2 (init lost), and no further byte is sent.
- R7: After the byte flagged last has been sent, the block sends complete filler bytes of value 0xFF until done is high at a byte boundary.
- R8: If done is still low at a byte boundary after DONE_TIMEOUT cycles of the filler phase, the run ends with error code 3 (done timeout).
- R9: Success (ok high, error low, code 0) is reported only when init and done are both high in the final cycle of the run. Done high with init low in that cycle gives error code 2.
- R10: An abort input returns the block to idle in the next cycle from any state, with the status flags cleared.
- R11: In idle, busy is low and the program-reset output and configuration clock are high. The ok flag, the error flag and the error code keep their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins a configuration run |
| abort_i | input | 1 | Return to idle from any state |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Block can take a byte |
| tgt_prog_n_o | output | 1 | Program-reset to target, active low |
| tgt_cclk_o | output | 1 | Configuration clock to target |
| tgt_din_o | output | 1 | Serial data bit to target |
| tgt_init_i | input | 1 | Target init status |
| tgt_done_i | input | 1 | Target done status |
| busy_o | output | 1 | A run is in progress |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 1 | Last run failed |
| err_code_o | output | 2 | 0 none, 1 init timeout, 2 init lost, 3 done timeout |

## Verification
A target model on the bench rebuilds each byte from the rising clock edges and checks it against a queue of the bytes the stream delivered. The image bytes mix bit values and have gaps between them on the stream. This separates bit order and data stability from the timing of the stream. The target model is set to raise done after the image, before it ends, or never, and to drop init during the load or never raise it. These runs separate the filler phase, the early exit, the done timeout, the init fault and the init timeout by their error codes and by the counts of filler and image bytes. A separate run aborts in the middle of a byte and checks that the pins and status fall back to their idle values.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG_LOW,
      ST_WAIT_INIT,
      ST_LOAD,
      ST_FLUSH,
      ST_FINISH
   } cfgl_state_e;

   typedef enum logic [1:0] {
      ERR_NONE         = 2'd0,
      ERR_INIT_TIMEOUT = 2'd1,
      ERR_INIT_LOST    = 2'd2,
      ERR_DONE_TIMEOUT = 2'd3
   } cfgl_err_e;

   localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic expired_o
);
   localparam int CW = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (LIMIT >= 0) else $error("cfgl_timer: LIMIT must not be negative");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clr_i)           cnt_q <= '0;
      else if (en_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/cfgl_bit_shifter.sv
module cfgl_bit_shifter #(
   parameter int HALF_DIV = 2,
   parameter int BYTE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill_i,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              busy_o,
   output logic              cclk_o,
   output logic              din_o
);
   localparam int BW = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sreg_q;
   logic [BW-1:0]     left_q;
   logic              busy_q;
   logic              cclk_q;
   logic              tick;
   logic              tick_clr;

   initial begin
      assert (HALF_DIV >= 1) else $error("cfgl_bit_shifter: HALF_DIV must be at least 1");
      assert (BYTE_W >= 2)   else $error("cfgl_bit_shifter: BYTE_W must be at least 2");
   end

   assign tick_clr = kill_i || !busy_q || tick;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = busy_q;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         localparam logic [DW-1:0] DLAST = DW'(HALF_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        div_q <= '0;
            else if (tick_clr) div_q <= '0;
            else               div_q <= div_q + 1'b1;
         end
         assign tick = busy_q && (div_q == DLAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '1;
         left_q <= '0;
         busy_q <= 1'b0;
         cclk_q <= 1'b1;
      end else if (kill_i) begin
         busy_q <= 1'b0;
         cclk_q <= 1'b1;
      end else if (!busy_q) begin
         if (load_i) begin
            sreg_q <= byte_i;
            left_q <= BW'(BYTE_W - 1);
            busy_q <= 1'b1;
            cclk_q <= 1'b0;
         end
      end else if (tick) begin
         if (!cclk_q) begin
            cclk_q <= 1'b1;
         end else if (left_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            sreg_q <= {sreg_q[BYTE_W-2:0], 1'b1};
            left_q <= left_q - 1'b1;
            cclk_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;
   assign cclk_o = cclk_q;
   assign din_o  = sreg_q[BYTE_W-1];

   assert_din_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cclk_o && $past(cclk_o)) |-> $stable(din_o));

   assert_load_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !busy_o);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
   parameter int HALF_DIV     = 2,
   parameter int PROG_LOW_CYC = 4,
   parameter int INIT_TIMEOUT = 50,
   parameter int DONE_TIMEOUT = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       abort_i,
   input  logic [7:0] s_data_i,
   input  logic       s_valid_i,
   input  logic       s_last_i,
   output logic       s_ready_o,
   output logic       tgt_prog_n_o,
   output logic       tgt_cclk_o,
   output logic       tgt_din_o,
   input  logic       tgt_init_i,
   input  logic       tgt_done_i,
   output logic       busy_o,
   output logic       ok_o,
   output logic       err_o,
   output logic [1:0] err_code_o
);
   import cfgl_pkg::*;

   cfgl_state_e state_q, state_d;
   cfgl_err_e   code_q, code_d;
   logic        ok_q, ok_d, err_q, err_d;
   logic        last_q, last_d;
   logic        sh_busy, sh_load, sh_kill;
   logic [7:0]  sh_byte;
   logic        plow_exp, init_exp, done_exp;
   logic        take;

   initial begin
      assert (PROG_LOW_CYC >= 1) else $error("cfg_serial_loader: PROG_LOW_CYC must be at least 1");
      assert (INIT_TIMEOUT >= 1) else $error("cfg_serial_loader: INIT_TIMEOUT must be at least 1");
      assert (DONE_TIMEOUT >= 1) else $error("cfg_serial_loader: DONE_TIMEOUT must be at least 1");
   end

   cfgl_timer #(.LIMIT(PROG_LOW_CYC - 1)) u_plow_tmr (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q != ST_PROG_LOW), .en_i(1'b1), .expired_o(plow_exp));

   cfgl_timer #(.LIMIT(INIT_TIMEOUT)) u_init_tmr (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q != ST_WAIT_INIT), .en_i(1'b1), .expired_o(init_exp));

   cfgl_timer #(.LIMIT(DONE_TIMEOUT)) u_done_tmr (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q != ST_FLUSH), .en_i(1'b1), .expired_o(done_exp));

   cfgl_bit_shifter #(.HALF_DIV(HALF_DIV), .BYTE_W(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .kill_i(sh_kill), .load_i(sh_load),
      .byte_i(sh_byte), .busy_o(sh_busy), .cclk_o(tgt_cclk_o), .din_o(tgt_din_o));

   assign s_ready_o = (state_q == ST_LOAD) && !sh_busy && !last_q
                      && tgt_init_i && !tgt_done_i;
   assign take      = s_ready_o && s_valid_i;

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      ok_d    = ok_q;
      err_d   = err_q;
      last_d  = last_q;
      sh_load = 1'b0;
      sh_kill = 1'b0;
      sh_byte = s_data_i;
      if (abort_i) begin
         state_d = ST_IDLE;
         ok_d    = 1'b0;
         err_d   = 1'b0;
         code_d  = ERR_NONE;
         sh_kill = 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_d = ST_PROG_LOW;
                  ok_d    = 1'b0;
                  err_d   = 1'b0;
                  code_d  = ERR_NONE;
                  last_d  = 1'b0;
               end
            end
            ST_PROG_LOW: begin
               if (plow_exp) state_d = ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
               if (tgt_init_i) begin
                  state_d = ST_LOAD;
               end else if (init_exp) begin
                  state_d = ST_IDLE;
                  err_d   = 1'b1;
                  code_d  = ERR_INIT_TIMEOUT;
               end
            end
            ST_LOAD: begin
               if (!tgt_init_i) begin
                  state_d = ST_IDLE;
                  err_d   = 1'b1;
                  code_d  = ERR_INIT_LOST;
                  sh_kill = 1'b1;
               end else if (!sh_busy) begin
                  if (tgt_done_i) begin
                     state_d = ST_FINISH;
                  end else if (last_q) begin
                     state_d = ST_FLUSH;
                  end else if (take) begin
                     sh_load = 1'b1;
                     last_d  = s_last_i;
                  end
               end
            end
            ST_FLUSH: begin
               sh_byte = FILL_BYTE;
               if (!sh_busy) begin
                  if (tgt_done_i) begin
                     state_d = ST_FINISH;
                  end else if (done_exp) begin
                     state_d = ST_IDLE;
                     err_d   = 1'b1;
                     code_d  = ERR_DONE_TIMEOUT;
                  end else begin
                     sh_load = 1'b1;
                  end
               end
            end
            ST_FINISH: begin
               state_d = ST_IDLE;
               if (tgt_init_i && tgt_done_i) begin
                  ok_d = 1'b1;
               end else begin
                  err_d  = 1'b1;
                  code_d = ERR_INIT_LOST;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= ERR_NONE;
         ok_q    <= 1'b0;
         err_q   <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         ok_q    <= ok_d;
         err_q   <= err_d;
         last_q  <= last_d;
      end
   end

   assign tgt_prog_n_o = (state_q != ST_PROG_LOW);
   assign busy_o       = (state_q != ST_IDLE);
   assign ok_o         = ok_q;
   assign err_o        = err_q;
   assign err_code_o   = code_q;

   assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (tgt_prog_n_o && tgt_cclk_o));

   assert_no_clock_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_cclk_o) |-> tgt_prog_n_o);

   assert_ok_needs_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_o) |-> $past(tgt_init_i && tgt_done_i));

   assert_init_lost_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD && !tgt_init_i && !abort_i) |=> (!busy_o && err_o && tgt_cclk_o));

   assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!busy_o && !ok_o && !err_o));
endmodule

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF   = 2;
   localparam int PLOW   = 4;
   localparam int INITTO = 50;
   localparam int DONETO = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, abort = 1'b0;
   logic [7:0] s_data = 8'h00;
   logic s_valid = 1'b0, s_last = 1'b0;
   logic s_ready, prog_n, cclk, din, busy, ok, err;
   logic [1:0] code;
   logic init_r = 1'b0, done_r = 1'b0;

   int n_checks = 0, n_err = 0;
   int init_delay = 10, done_after = -1, drop_after = -1;
   int init_cnt = 0, rx_cnt = 0, bitn = 0, dummy_cnt = 0, accepted = 0;
   int plow = 0, last_plow = 0, early_fall = 0, lowrun = 0, bad_half = 0;
   int ready_seen = 0;
   bit init_seen = 0, dropped = 0, check_timing = 0;
   logic [7:0] shreg = 8'h00;
   logic [7:0] exp_q[$];
   logic [7:0] img[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_serial_loader #(.HALF_DIV(HALF), .PROG_LOW_CYC(PLOW),
                       .INIT_TIMEOUT(INITTO), .DONE_TIMEOUT(DONETO)) u_cfg_serial_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
      .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
      .tgt_prog_n_o(prog_n), .tgt_cclk_o(cclk), .tgt_din_o(din),
      .tgt_init_i(init_r), .tgt_done_i(done_r),
      .busy_o(busy), .ok_o(ok), .err_o(err), .err_code_o(code));

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // target model: updates away from the active edge
   always @(negedge clk) begin
      if (!prog_n) begin
         init_r <= 1'b0; done_r <= 1'b0; init_cnt <= 0; dropped <= 0;
      end else begin
         if (!init_r && !dropped && init_delay >= 0) begin
            init_cnt <= init_cnt + 1;
            if (init_cnt + 1 >= init_delay) init_r <= 1'b1;
         end
         if (drop_after >= 0 && rx_cnt >= drop_after && init_r) begin
            init_r <= 1'b0; dropped <= 1;
         end
         if (done_after >= 0 && rx_cnt >= done_after) done_r <= 1'b1;
      end
      if (!prog_n) plow++;
      else if (plow != 0) begin last_plow = plow; plow = 0; end
      if (!cclk) lowrun++;
      else if (lowrun != 0) begin
         if (check_timing && lowrun != HALF) bad_half++;
         lowrun = 0;
      end
      if (s_ready) ready_seen++;
   end

   always @(posedge init_r) init_seen = 1;
   always @(negedge cclk) if (!init_seen) early_fall++;

   // scoreboard monitor: rebuild bytes on rising clock edges
   always @(posedge cclk) begin
      if (prog_n && busy) begin
         shreg = {shreg[6:0], din};
         bitn++;
         if (bitn == 8) begin
            bitn = 0;
            rx_cnt++;
            if (exp_q.size() > 0) begin
               chk("R3 byte order", int'(shreg), int'(exp_q.pop_front()));
            end else begin
               chk("R7 filler value", int'(shreg), 255);
               dummy_cnt++;
            end
         end
      end
   end

   task automatic prep(input int idly, input int dafter, input int drop);
      init_delay = idly; done_after = dafter; drop_after = drop;
      rx_cnt = 0; bitn = 0; dummy_cnt = 0; accepted = 0; ready_seen = 0;
      init_seen = 0; early_fall = 0; bad_half = 0; last_plow = 0;
      exp_q.delete();
   endtask

   task automatic run_image(input int gap);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      foreach (img[i]) begin
         s_valid = 1'b1; s_data = img[i]; s_last = (i == img.size() - 1);
         while (!s_ready && busy) @(negedge clk);
         if (!busy) break;
         exp_q.push_back(img[i]);
         accepted++;
         @(negedge clk);
         s_valid = 1'b0; s_last = 1'b0;
         for (int g = 0; g < gap; g++) @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
   endtask

   initial begin
      repeat (200000 - 50000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk("R11 reset busy", int'(busy), 0);
      chk("R11 reset prog_n", int'(prog_n), 1);
      chk("R11 reset cclk", int'(cclk), 1);
      chk("R4 reset ready", int'(s_ready), 0);
      chk("R11 reset ok/err", int'({ok, err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // normal run with filler, gaps between bytes
      prep(10, 6, -1);
      check_timing = 1;
      img = '{8'hA5, 8'h3C, 8'h01, 8'h80};
      run_image(3);
      chk("R1 prog low width", last_plow, PLOW);
      chk("R1 no clock before init", early_fall, 0);
      chk("R3 half period", bad_half, 0);
      chk("R3 all image bytes seen", exp_q.size(), 0);
      chk("R7 filler count", dummy_cnt, 2);
      chk("R9 ok", int'(ok), 1);
      chk("R9 code", int'({err, code}), 0);
      chk("R11 idle pins", int'({busy, prog_n, cclk}), 3);
      repeat (20) @(negedge clk);
      chk("R11 ok held", int'(ok), 1);

      // early done
      prep(5, 3, -1);
      img = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
      run_image(0);
      check_timing = 0;
      chk("R5 accepted", accepted, 3);
      chk("R5 received", rx_cnt, 3);
      chk("R5 no filler", dummy_cnt, 0);
      chk("R5 ok", int'({ok, err}), 2);

      // init lost during load
      prep(5, -1, 2);
      img = '{8'hF0, 8'h0F, 8'hAA, 8'h55, 8'hC3};
      run_image(0);
      chk("R6 err flag", int'(err), 1);
      chk("R6 code", int'(code), 2);
      chk("R6 received", rx_cnt, 2);
      chk("R6 cclk idle", int'(cclk), 1);
      chk("R9 no ok", int'(ok), 0);

      // init timeout
      prep(-1, -1, -1);
      img = '{8'h11};
      run_image(0);
      chk("R2 err flag", int'(err), 1);
      chk("R2 code", int'(code), 1);
      chk("R2 no ready", ready_seen, 0);
      chk("R2 no bits", rx_cnt + bitn, 0);

      // done timeout
      prep(5, -1, -1);
      img = '{8'h5A, 8'hE7};
      run_image(1);
      chk("R8 err flag", int'(err), 1);
      chk("R8 code", int'(code), 3);
      chk("R8 image", rx_cnt - dummy_cnt, 2);
      chk("R7 some filler", int'(dummy_cnt >= 1), 1);

      // abort mid byte
      prep(5, -1, -1);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      s_valid = 1'b1; s_data = 8'h3E; s_last = 1'b0;
      while (!s_ready) @(negedge clk);
      @(negedge clk) s_valid = 1'b0;
      repeat (7) @(negedge clk);
      chk("R10 busy before abort", int'(busy), 1);
      abort = 1'b1;
      @(negedge clk) abort = 1'b0;
      chk("R10 busy", int'(busy), 0);
      chk("R10 pins", int'({prog_n, cclk}), 3);
      chk("R10 status", int'({ok, err}), 0);

      summary();
      $finish;
   end
endmodule